// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations for a 32-bit address space with 4 KiB pages. A lookup presents a virtual address, and the virtual page number in its upper 20 bits is compared against every stored entry in the same cycle. On a match the block returns the physical address, which is the stored frame number placed above the untouched 12-bit page offset. It also returns the entry's protection bits and a hit flag. On a miss it raises a walk request. The page-table walk runs outside the block, and its result comes back through a refill port. That port copies the walker's frame number, protection, use and dirty bits into one entry, bit for bit.

Each entry carries its own use and dirty state next to the translation. A hit marks the entry as used. The first store to a clean entry asks for the page-table dirty bit to be updated and marks the entry dirty. A store to a page without write permission faults. A separate port lets software remove the translation for a named virtual page. After that, the stale mapping can never hit again.

The refill victim is chosen without any per-set history. The block takes an empty slot first. If there is none, it takes the lowest entry that has not been used since the last sweep. If every entry has been used, the use bits are swept clear and entry 0 is replaced. All lookup outputs are combinational on the lookup inputs, and all state changes take effect at the next rising clock edge.

Top module: `page_xlate_tlb`

## Requirements
- R1: On a lookup hit, `lk_paddr` equals the stored 20-bit frame number in bits 31:12 concatenated with `lk_vaddr[11:0]`, and `lk_prot` equals the stored protection field.
- R2: A lookup whose page number (`lk_vaddr[31:12]`) matches no valid entry drives `lk_miss` high, with `lk_hit`, `lk_fault` and `lk_dirty_upd` low.
- R3: A refill writes the supplied page number, frame number, protection, use bit and dirty bit into one entry exactly as given and marks it valid. A later lookup of that page returns those values.
- R4: An invalidate removes every valid entry whose page number equals `inv_vpn`, so a later lookup of that page misses. Entries for other pages remain and still hit.
- R5: A lookup hit sets the use bit of the entry that hit. This shows at the ports in the choice of the next refill victim.
- R6: A store lookup (`lk_store`=1) that hits an entry whose dirty bit is clear raises `lk_dirty_upd` in that cycle and sets the dirty bit. A second store to the same page then gives no `lk_dirty_upd`. A store hit on an entry refilled with its dirty bit set gives none either.
- R7: Bit 1 of the protection field grants write permission. A store that matches an entry with bit 1 clear drives `lk_fault` high, with `lk_hit`, `lk_miss` and `lk_dirty_upd` low.
- R8: When at least one entry is invalid, a refill writes the lowest-numbered invalid entry.
- R9: When all entries are valid and at least one has a clear use bit, a refill writes the lowest-numbered entry with a clear use bit.
- R10: When all entries are valid and all use bits are set, a refill clears every use bit and writes entry 0. Entry 0 takes the refill's own use bit.
- R11: Reset (synchronous, active low) invalidates every entry, so every lookup after reset misses.
- R12: While `lk_valid` is low, `lk_hit`, `lk_miss`, `lk_fault` and `lk_dirty_upd` are all low, even when the address would hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | Lookup is a write access |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | No translation; page-table walk needed |
| lk_fault | output | 1 | Store to a page without write permission |
| lk_dirty_upd | output | 1 | First store to a clean page; page-table dirty bit needs updating |
| lk_paddr | output | 32 | Physical address, meaningful on hit |
| lk_prot | output | 3 | Protection field of the matching entry |
| rf_valid | input | 1 | Refill request this cycle |
| rf_vpn | input | 20 | Virtual page number of the refill |
| rf_pfn | input | 20 | Physical frame number of the refill |
| rf_prot | input | 3 | Protection field of the refill |
| rf_use | input | 1 | Use bit of the refill |
| rf_dirty | input | 1 | Dirty bit of the refill |
| inv_valid | input | 1 | Invalidate request this cycle |
| inv_vpn | input | 20 | Virtual page number to invalidate |

## Verification
A wrong frame, protection or dirty bit in an entry shows at the ports on the very next lookup of that page. It appears as a bad physical address, a fault that should not occur, or a missing or extra dirty-update pulse. Errors in valid or use bits are harder to see. A wrong valid bit shows only when that page is looked up. A wrong use bit stays hidden until a refill finds the buffer full and evicts the wrong entry, which is why the bench pairs each sequence of hits with a refill and then looks up every stored page. The bench keeps its own reference model of the entries, built from the requirements, and compares each lookup against it.

// File: rtl/pxt_pkg.sv
// Package pxt_pkg: address split and entry layout shared by the translation
// buffer and its sub-blocks. Assumes a page size of 2**OFF_W bytes.
package pxt_pkg;
    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int PFN_W     = 20;
    localparam int PA_W      = PFN_W + OFF_W;
    localparam int PROT_W    = 3;
    localparam int PROT_WR   = 1;   // protection bit that grants write access

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [PROT_W-1:0] prot;
        logic              used;
        logic              dirty;
    } pxt_entry_t;
endpackage

// File: rtl/pxt_match.sv
// Module pxt_match: compares one key against every stored page number in
// parallel and reports the lowest-numbered valid match.
// Assumes N >= 2. With duplicate pages present, the lowest index wins.
module pxt_match #(
    parameter int N  = 8,
    parameter int TW = 20,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0][TW-1:0] tags,
    input  logic [N-1:0]         vld,
    input  logic [TW-1:0]        key,
    output logic [N-1:0]         hitv,
    output logic                 any,
    output logic [IW-1:0]        idx
);
    // one comparator per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hitv[g] = vld[g] && (tags[g] == key);
    end

    assign any = |hitv;

    // priority encode: lowest matching index
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hitv[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pxt_victim.sv
// Module pxt_victim: picks the entry a refill overwrites.
// Order: lowest invalid entry, else lowest entry with clear use bit, else
// entry 0 with all_used raised so the caller sweeps the use bits.
module pxt_victim #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  vld,
    input  logic [N-1:0]  used,
    output logic [IW-1:0] vic_idx,
    output logic          all_used
);
    logic          have_free, have_cold;
    logic [IW-1:0] free_idx, cold_idx;

    // scan for the lowest free and the lowest cold entry
    always_comb begin
        have_free = 1'b0;
        have_cold = 1'b0;
        free_idx  = '0;
        cold_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                have_free = 1'b1;
                free_idx  = IW'(i);
            end
            if (!used[i]) begin
                have_cold = 1'b1;
                cold_idx  = IW'(i);
            end
        end
    end

    // final choice by rule order
    always_comb begin
        all_used = !have_free && !have_cold;
        if (have_free)      vic_idx = free_idx;
        else if (have_cold) vic_idx = cold_idx;
        else                vic_idx = '0;
    end

    // a free slot exists, so the pick must be free
    assert_pick_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld != '1) |-> !vld[vic_idx]);

    // buffer full but some entry cold, so the pick must be cold
    assert_pick_cold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((vld == '1) && (used != '1)) |-> !used[vic_idx]);
endmodule

// File: rtl/page_xlate_tlb.sv
// Module page_xlate_tlb: fully associative translation buffer.
// Lookup outputs are combinational. Refill, invalidate, use and dirty updates
// land at the rising edge. Same-cycle order: lookup effects, then invalidate,
// then refill (the refill wins on its victim). Only valid bits are reset.
module page_xlate_tlb
    import pxt_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IW = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_store,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic              lk_dirty_upd,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [PROT_W-1:0] lk_prot,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic [PROT_W-1:0] rf_prot,
    input  logic              rf_use,
    input  logic              rf_dirty,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn
);
    pxt_entry_t                   ent_q [N_ENT];
    logic [N_ENT-1:0]             vld_q;
    logic [N_ENT-1:0][VPN_W-1:0]  tags;
    logic [N_ENT-1:0]             used_v;
    logic [N_ENT-1:0]             lk_hitv;
    logic [N_ENT-1:0]             inv_hitv;
    logic                         lk_any;
    logic [IW-1:0]                lk_idx;
    logic [IW-1:0]                vic_idx;
    logic                         all_used;
    pxt_entry_t                   sel;
    logic                         wr_ok;

    // flatten entry fields for the comparator and victim picker
    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            tags[i]   = ent_q[i].vpn;
            used_v[i] = ent_q[i].used;
        end
    end

    pxt_match #(.N(N_ENT), .TW(VPN_W)) u_lk_match (
        .tags (tags),
        .vld  (vld_q),
        .key  (lk_vaddr[VA_W-1:OFF_W]),
        .hitv (lk_hitv),
        .any  (lk_any),
        .idx  (lk_idx)
    );

    // invalidate comparators, one per entry
    for (genvar g = 0; g < N_ENT; g++) begin : g_inv
        assign inv_hitv[g] = vld_q[g] && (ent_q[g].vpn == inv_vpn);
    end

    pxt_victim #(.N(N_ENT)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (vld_q),
        .used     (used_v),
        .vic_idx  (vic_idx),
        .all_used (all_used)
    );

    // lookup response from the selected entry
    always_comb begin
        sel          = ent_q[lk_idx];
        wr_ok        = sel.prot[PROT_WR];
        lk_miss      = lk_valid && !lk_any;
        lk_fault     = lk_valid && lk_any && lk_store && !wr_ok;
        lk_hit       = lk_valid && lk_any && !(lk_store && !wr_ok);
        lk_dirty_upd = lk_hit && lk_store && !sel.dirty;
        lk_paddr     = {sel.pfn, lk_vaddr[OFF_W-1:0]};
        lk_prot      = sel.prot;
    end

    // valid bits: reset, invalidate, refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (inv_valid) vld_q <= vld_q & ~inv_hitv;
            if (rf_valid) begin
                for (int i = 0; i < N_ENT; i++) begin
                    if (IW'(i) == vic_idx) vld_q[i] <= 1'b1;
                    else if (inv_valid && inv_hitv[i]) vld_q[i] <= 1'b0;
                end
            end
        end
    end

    // entry contents: use/dirty marking, use sweep, refill write
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENT; i++) begin
            if (lk_hit && lk_idx == IW'(i)) begin
                ent_q[i].used <= 1'b1;
                if (lk_store) ent_q[i].dirty <= 1'b1;
            end
            if (rf_valid && all_used) ent_q[i].used <= 1'b0;
            if (rf_valid && vic_idx == IW'(i)) begin
                ent_q[i] <= '{vpn: rf_vpn, pfn: rf_pfn, prot: rf_prot,
                              used: rf_use, dirty: rf_dirty};
            end
        end
    end

    // outcome flags are mutually exclusive
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lk_hit, lk_miss, lk_fault}) <= 1);

    // idle lookup port is silent
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault || lk_dirty_upd));

    // a dirty-update request only accompanies a store hit
    assert_upd_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_dirty_upd |-> (lk_hit && lk_store));

    // the dirty bit is set after a store hit (no refill in that cycle)
    assert_dirty_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_store && !rf_valid) |=> ent_q[$past(lk_idx)].dirty);

    // a hit marks its entry used (no refill in that cycle)
    assert_use_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !rf_valid) |=> ent_q[$past(lk_idx)].used);

    // an invalidated page leaves no valid copy
    assert_inv_gone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !rf_valid) |=> ((vld_q & $past(inv_hitv)) == '0));

    // a full sweep replaces entry 0
    assert_sweep_slot0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && all_used) |=> vld_q[0] && (ent_q[0].vpn == $past(rf_vpn)));

    // coming out of reset, nothing is valid
    assert_reset_empty_R11: assert property (@(posedge clk)
        $rose(rst_n) |-> (vld_q == '0));
endmodule

// File: tb/tb_page_xlate_tlb.sv
`timescale 1ns/1ps
module tb_page_xlate_tlb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_store = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty_upd;
    logic [31:0] lk_paddr;
    logic [2:0]  lk_prot;
    logic        rf_valid = 1'b0, rf_use = 1'b0, rf_dirty = 1'b0;
    logic [19:0] rf_vpn = '0, rf_pfn = '0;
    logic [2:0]  rf_prot = '0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;

    int tests = 0, fails = 0;
    bit done = 0;

    // reference model of the entries
    logic [19:0] m_vpn [N];
    logic [19:0] m_pfn [N];
    logic [2:0]  m_prot [N];
    logic        m_v [N], m_u [N], m_d [N];

    always #2 clk = ~clk;

    page_xlate_tlb #(.N_ENT(N)) dut (.*);

    task automatic check(input string req, input bit ok, input string got, input string exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %s expected %s", req, got, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] va, input logic st, input string req);
        int   k;
        logic e_hit, e_miss, e_fault, e_upd;
        logic [31:0] e_pa;
        logic [2:0]  e_prot;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_store = st;
        #1;
        k = -1;
        for (int i = N - 1; i >= 0; i--) if (m_v[i] && m_vpn[i] == va[31:12]) k = i;
        e_miss = (k < 0);
        e_fault = (k >= 0) && st && !m_prot[k][1];
        e_hit = (k >= 0) && !e_fault;
        e_upd = e_hit && st && !m_d[k];
        e_pa = (k >= 0) ? {m_pfn[k], va[11:0]} : 32'h0;
        e_prot = (k >= 0) ? m_prot[k] : 3'h0;
        check(req, {lk_hit, lk_miss, lk_fault, lk_dirty_upd} == {e_hit, e_miss, e_fault, e_upd}
                   && (!e_hit || (lk_paddr == e_pa && lk_prot == e_prot)),
              $sformatf("h%b m%b f%b u%b pa=%h pr=%h", lk_hit, lk_miss, lk_fault, lk_dirty_upd, lk_paddr, lk_prot),
              $sformatf("h%b m%b f%b u%b pa=%h pr=%h", e_hit, e_miss, e_fault, e_upd, e_pa, e_prot));
        if (e_hit) begin
            m_u[k] = 1'b1;
            if (st) m_d[k] = 1'b1;
        end
        @(posedge clk); #1;
        lk_valid = 1'b0; lk_store = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] prot,
                          input logic u, input logic d);
        int vic, cold;
        vic = -1; cold = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!m_v[i]) vic = i;
            if (!m_u[i]) cold = i;
        end
        if (vic < 0) begin
            if (cold >= 0) vic = cold;
            else begin
                for (int i = 0; i < N; i++) m_u[i] = 1'b0;
                vic = 0;
            end
        end
        m_vpn[vic] = vpn; m_pfn[vic] = pfn; m_prot[vic] = prot;
        m_u[vic] = u; m_d[vic] = d; m_v[vic] = 1'b1;
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = vpn; rf_pfn = pfn; rf_prot = prot; rf_use = u; rf_dirty = d;
        @(posedge clk); #1;
        rf_valid = 1'b0;
    endtask

    task automatic invalidate(input logic [19:0] vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) m_v[i] = 1'b0;
        @(negedge clk);
        inv_valid = 1'b1; inv_vpn = vpn;
        @(posedge clk); #1;
        inv_valid = 1'b0;
    endtask

    task automatic sweep_model(input string req);
        for (int i = 0; i < N; i++) if (m_v[i]) lookup({m_vpn[i], 12'h5a4}, 1'b0, req);
    endtask

    function automatic logic [19:0] pg(input int i);
        return 20'h00100 + 20'(i * 17);
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_u[i] = 0; m_d[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_prot[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 / R2: empty after reset, every page misses
        for (int p = 0; p < 16; p++) lookup({20'(p), 12'h010}, p[0], "R11");
        lookup({pg(3), 12'h000}, 1'b0, "R2");

        // R3 / R8: fill all slots, free slots taken in order
        for (int i = 0; i < N; i++) refill(pg(i), 20'hA0000 ^ 20'(i * 4099), 3'(i % 4), 1'b0, 1'(i & 1));

        // R1: translation at several offsets for every entry
        for (int i = 0; i < N; i++) begin
            lookup({pg(i), 12'h000}, 1'b0, "R1");
            lookup({pg(i), 12'hfff}, 1'b0, "R1");
            lookup({pg(i), 12'(i * 291)}, 1'b0, "R3");
        end

        // R12: idle port stays silent on a hitting address
        @(negedge clk);
        lk_valid = 1'b0; lk_vaddr = {pg(2), 12'h004}; lk_store = 1'b1;
        #1;
        check("R12", {lk_hit, lk_miss, lk_fault, lk_dirty_upd} == 4'b0,
              $sformatf("%b", {lk_hit, lk_miss, lk_fault, lk_dirty_upd}), "0000");
        @(posedge clk); #1 lk_store = 1'b0;

        // R6 / R7: stores to every entry twice; writable clean ones ask once
        for (int i = 0; i < N; i++) lookup({pg(i), 12'h020}, 1'b1, (i % 4 >= 2) ? "R6" : "R7");
        for (int i = 0; i < N; i++) lookup({pg(i), 12'h024}, 1'b1, (i % 4 >= 2) ? "R6" : "R7");

        // R4: remove one page, others untouched; unknown page is harmless
        invalidate(pg(5));
        lookup({pg(5), 12'h100}, 1'b0, "R4");
        invalidate(20'hFFFFF);
        sweep_model("R4");

        // R8: refill lands in the freed slot, nothing else evicted
        refill(20'h0BEEF, 20'h12345, 3'b011, 1'b0, 1'b0);
        sweep_model("R8");
        lookup({20'h0BEEF, 12'h777}, 1'b0, "R8");

        // R10: every use bit set now, so entry 0 is replaced and use bits swept
        refill(20'h0CAFE, 20'h54321, 3'b010, 1'b0, 1'b0);
        lookup({pg(0), 12'h000}, 1'b0, "R10");
        lookup({20'h0CAFE, 12'h888}, 1'b1, "R10");

        // R5 / R9: entry 0 used just now; mark 1 and 2 used, then 3 must go
        lookup({pg(1), 12'h000}, 1'b0, "R5");
        lookup({pg(2), 12'h000}, 1'b0, "R5");
        refill(20'h0D00D, 20'h0F0F0, 3'b111, 1'b1, 1'b1);
        lookup({pg(3), 12'h000}, 1'b0, "R9");
        lookup({20'h0D00D, 12'h0ab}, 1'b1, "R3");
        sweep_model("R9");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule